// File: doc/BRIEF.md
# Float-to-Integer Converter with Selectable Overflow Policy

This block turns a 64-bit binary floating-point operand into a signed or unsigned integer of 32 or 64 bits. The operand can also be a single-precision value held in double layout. Every result is delivered as 64 bits. A 3-bit mode chooses the rounding and the out-of-range policy. There are three policies:
- Saturate, with NaN mapped to the type minimum.
- Saturate, with NaN mapped to zero.
- Wrap modulo 2^N, as scripting languages require.

The rounding is either forced truncation or the 2-bit rounding field of the floating-point status.

Alongside the result, the block reports a write enable, an illegal-mode indication and a set of flags. The flags cover invalid conversion, signalling NaN, inexact, fraction-rounded and an integer overflow. Overflow means the integer does not equal the source value. A condition-register nibble is also produced. The converter is a single registered stage: an operand accepted with `in_valid` appears one cycle later with `out_valid`. Raising the exception trap itself is left to the surrounding pipeline.

Top module: `fp_to_int_cvt`

## Requirements
- R1: `int_kind` selects the target: 0 signed 32-bit, 1 unsigned 32-bit, 2 signed 64-bit, 3 unsigned 64-bit. A signed 32-bit result is sign-extended to 64 bits and an unsigned 32-bit result is zero-extended.
- R2: `conv_mode` bits [2:1] pick the policy: 00 saturate with NaN to minimum, 01 saturate with NaN to zero, 10 wrap. Modes 110 and 111 assert `bad_mode`, leave `wr_en` low, and give a zero result, zero flags and zero `cr0`.
- R3: If `conv_mode[0]` is 1, the value is truncated toward zero. Otherwise `rnd_mode` applies: 00 nearest with ties to even, 01 toward zero, 10 toward +infinity, 11 toward -infinity.
- R4: Under both saturating policies, a rounded value above the type maximum gives the maximum, and one below the type minimum gives the minimum. Infinities count as out of range.
- R5: A NaN gives the type minimum under policy 00 and zero under policy 01. Under the wrap policy, NaN and both infinities give zero.
- R6: Under the wrap policy, the rounded integer is reduced modulo 2^64 and then reinterpreted in the target type; for 32-bit types, modulo 2^32.
- R7: `ov_flag` is `ov_enable` AND (source is NaN OR the integer written is not numerically equal to the source). It is zero when nothing is written, and `cr0[0]` mirrors it.
- R8: `inv_cvt` is set for NaN and, under the saturating policies, for any out-of-range value. Under the wrap policy it is set only for NaN and infinity. `snan_flag` is set for a NaN whose fraction bit 51 is 0.
- R9: If `inv_trap_en` is 1 and `inv_cvt` or `snan_flag` is raised, `wr_en` is 0 and the result, `fi_flag`, `fr_flag`, `ov_flag` and `cr0` are zero. Valid conversions are unaffected by `inv_trap_en`.
- R10: `fi_flag` marks a discarded fraction in a written, non-saturated result. `fr_flag` marks that rounding raised the magnitude.
- R11: With `single_sel` set, fraction bits [28:0] of the operand are ignored before conversion.
- R12: When written, `cr0` = {LT, GT, EQ, SO}, computed from the 64-bit result taken as signed.
- R13: Reset clears `out_valid` and all outputs. `out_valid` follows `in_valid` one cycle later and stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand and controls are valid this cycle |
| fp_bits | input | 64 | Floating-point operand in double layout |
| int_kind | input | 2 | Target integer type |
| conv_mode | input | 3 | Policy and truncation select |
| rnd_mode | input | 2 | Rounding field from the status register |
| single_sel | input | 1 | Treat the operand as single precision |
| ov_enable | input | 1 | Report integer overflow |
| inv_trap_en | input | 1 | Invalid-operation exception enabled |
| out_valid | output | 1 | Result registers hold a new conversion |
| result | output | 64 | Converted integer |
| wr_en | output | 1 | Destination must be written |
| bad_mode | output | 1 | Illegal conversion mode |
| ov_flag | output | 1 | Integer overflow (inexact or saturated or NaN) |
| inv_cvt | output | 1 | Invalid conversion |
| snan_flag | output | 1 | Signalling NaN operand |
| fi_flag | output | 1 | Fraction inexact |
| fr_flag | output | 1 | Fraction rounded up |
| cr0 | output | 4 | LT, GT, EQ, SO of the result |

## Verification
The hardest cases to reach are those where the mode bit, the rounding field and the type interact at a type boundary. One is 2^31, which wraps to the signed minimum in wrap mode but saturates in the other modes. Another is the single-precision path, where the only difference lies in fraction bits below bit 29. The stimulus reaches these with hand-built operand encodings. These include 2^32+5, 2^30+0.5 under upward rounding with and without `single_sel`, ±2^63, and a quiet and a signalling NaN. All are streamed back to back, so every stage holds a different case in each cycle.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

    localparam int DBL_W    = 64;
    localparam int EXP_W    = 11;
    localparam int FRAC_W   = 52;
    localparam int SIG_W    = FRAC_W + 1;
    localparam int BIAS     = 1023;
    localparam int INT_W    = 64;
    localparam int HALF_W   = INT_W / 2;
    localparam int NARROW_W = 29;
    localparam int FRAC_SH  = BIAS + FRAC_W;
    localparam int SH_W     = SIG_W + INT_W;
    localparam int SHAMT_W  = $clog2(SH_W);
    localparam int SH_MAX   = SIG_W + 1;
    localparam int QUIET_B  = FRAC_W - 1;

    typedef enum logic [1:0] {
        K_S32 = 2'd0,
        K_U32 = 2'd1,
        K_S64 = 2'd2,
        K_U64 = 2'd3
    } int_kind_e;

    typedef enum logic [1:0] {
        RM_NEAR = 2'd0,
        RM_ZERO = 2'd1,
        RM_UP   = 2'd2,
        RM_DOWN = 2'd3
    } rnd_e;

    typedef enum logic [1:0] {
        POL_SAT_MIN  = 2'd0,
        POL_SAT_ZERO = 2'd1,
        POL_WRAP     = 2'd2,
        POL_BAD      = 2'd3
    } policy_e;

    typedef struct packed {
        logic             sign;
        logic             is_nan;
        logic             is_inf;
        logic [EXP_W-1:0] exp;
        logic [SIG_W-1:0] sig;
    } unpacked_t;

    typedef struct packed {
        logic             sign;
        logic             nan;
        logic             inf;
        logic             big;
        logic [INT_W-1:0] mag;
        logic             inexact;
        logic             incr;
    } rounded_t;

    function automatic policy_e decode_policy(input logic [2:0] mode);
        return policy_e'(mode[2:1]);
    endfunction

    function automatic logic [INT_W-1:0] kind_max(input int_kind_e k);
        logic [INT_W-1:0] one;
        one = INT_W'(1);
        case (k)
            K_S32:   return (one << (HALF_W - 1)) - one;
            K_U32:   return (one << HALF_W) - one;
            K_S64:   return ~(one << (INT_W - 1));
            default: return '1;
        endcase
    endfunction

    function automatic logic [INT_W-1:0] kind_min(input int_kind_e k);
        logic [INT_W-1:0] one;
        one = INT_W'(1);
        case (k)
            K_S32:   return ~((one << (HALF_W - 1)) - one);
            K_S64:   return one << (INT_W - 1);
            default: return '0;
        endcase
    endfunction

    function automatic logic [INT_W-1:0] fit_kind(input int_kind_e k, input logic [INT_W-1:0] v);
        case (k)
            K_S32:   return {{HALF_W{v[HALF_W-1]}}, v[HALF_W-1:0]};
            K_U32:   return {{HALF_W{1'b0}}, v[HALF_W-1:0]};
            default: return v;
        endcase
    endfunction

endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack
    import f2i_pkg::*;
#(
    parameter int CUT_W = NARROW_W
) (
    input  logic [DBL_W-1:0] bits_i,
    input  logic             narrow_i,
    output unpacked_t        u_o,
    output logic             snan_o
);
    logic [FRAC_W-1:0] frac_raw;
    logic [FRAC_W-1:0] frac_kept;
    logic [EXP_W-1:0]  ex;
    logic              nan_w;

    assign frac_raw = bits_i[FRAC_W-1:0];
    assign ex       = bits_i[DBL_W-2 -: EXP_W];
    assign nan_w    = (&ex) && (|frac_raw);

    generate
        if (CUT_W > 0) begin : g_narrow
            assign frac_kept = narrow_i ? {frac_raw[FRAC_W-1:CUT_W], {CUT_W{1'b0}}} : frac_raw;
        end else begin : g_full
            assign frac_kept = frac_raw;
        end
    endgenerate

    always_comb begin
        u_o.sign   = bits_i[DBL_W-1];
        u_o.is_nan = nan_w;
        u_o.is_inf = (&ex) && !(|frac_raw);
        u_o.exp    = ex;
        u_o.sig    = {|ex, frac_kept};
    end

    assign snan_o = nan_w && !frac_raw[QUIET_B];

endmodule

// File: rtl/f2i_round.sv
module f2i_round
    import f2i_pkg::*;
(
    input  unpacked_t u_i,
    input  rnd_e      rm_i,
    output rounded_t  r_o
);
    localparam int E_W = EXP_W + 2;

    logic signed [E_W-1:0] e_s;
    logic [E_W-1:0]        e_u;
    logic [E_W-1:0]        neg_e;
    logic [SHAMT_W-1:0]    sh;
    logic [SH_W-1:0]       wide_l;
    logic [SH_W-1:0]       wide_r;
    logic [SIG_W-1:0]      ip;
    logic                  guard;
    logic                  sticky;
    logic                  up;

    always_comb begin
        e_s    = $signed({2'b00, u_i.exp}) - $signed(E_W'(FRAC_SH));
        e_u    = e_s;
        neg_e  = -e_u;
        sh     = '0;
        wide_l = '0;
        wide_r = '0;
        ip     = '0;
        guard  = 1'b0;
        sticky = 1'b0;
        up     = 1'b0;
        r_o         = '0;
        r_o.sign    = u_i.sign;
        r_o.nan     = u_i.is_nan;
        r_o.inf     = u_i.is_inf;
        if (!e_s[E_W-1]) begin
            // integer-valued operand: left shift, no rounding
            if (e_u > E_W'(INT_W)) begin
                r_o.big = 1'b1;
            end else begin
                wide_l  = {{INT_W{1'b0}}, u_i.sig} << e_u[SHAMT_W-1:0];
                r_o.big = |wide_l[SH_W-1:INT_W];
                r_o.mag = wide_l[INT_W-1:0];
            end
        end else begin
            // fractional part present: right shift keeping guard and sticky
            sh     = (neg_e > E_W'(SH_MAX)) ? SHAMT_W'(SH_MAX) : neg_e[SHAMT_W-1:0];
            wide_r = {u_i.sig, {INT_W{1'b0}}} >> sh;
            ip     = wide_r[SH_W-1:INT_W];
            guard  = wide_r[INT_W-1];
            sticky = |wide_r[INT_W-2:0];
            case (rm_i)
                RM_NEAR: up = guard && (sticky || ip[0]);
                RM_ZERO: up = 1'b0;
                RM_UP:   up = (guard || sticky) && !u_i.sign;
                default: up = (guard || sticky) && u_i.sign;
            endcase
            r_o.mag     = INT_W'(ip) + INT_W'(up);
            r_o.inexact = guard || sticky;
            r_o.incr    = up;
        end
        if (u_i.is_inf) r_o.big = 1'b1;
    end

endmodule

// File: rtl/f2i_policy.sv
module f2i_policy
    import f2i_pkg::*;
(
    input  rounded_t         r_i,
    input  int_kind_e        kind_i,
    input  policy_e          pol_i,
    output logic [INT_W-1:0] res_o,
    output logic             inv_o,
    output logic             ovf_o,
    output logic             fi_o,
    output logic             fr_o
);
    localparam logic [INT_W-1:0] S32_EDGE = INT_W'(1) << (HALF_W - 1);
    localparam logic [INT_W-1:0] S64_EDGE = INT_W'(1) << (INT_W - 1);

    logic             over;
    logic             under;
    logic             oor;
    logic             lost;
    logic [INT_W-1:0] signed_v;

    always_comb begin
        case (kind_i)
            K_S32: begin
                over  = !r_i.sign && (r_i.big || r_i.mag >= S32_EDGE);
                under =  r_i.sign && (r_i.big || r_i.mag >  S32_EDGE);
            end
            K_U32: begin
                over  = !r_i.sign && (r_i.big || |r_i.mag[INT_W-1:HALF_W]);
                under =  r_i.sign && (r_i.big || |r_i.mag);
            end
            K_S64: begin
                over  = !r_i.sign && (r_i.big || r_i.mag[INT_W-1]);
                under =  r_i.sign && (r_i.big || r_i.mag > S64_EDGE);
            end
            default: begin
                over  = !r_i.sign && r_i.big;
                under =  r_i.sign && (r_i.big || |r_i.mag);
            end
        endcase
        oor      = (over || under) && !r_i.nan;
        lost     = r_i.inexact && !r_i.nan && !r_i.inf;
        signed_v = r_i.sign ? (~r_i.mag + INT_W'(1)) : r_i.mag;

        res_o = '0;
        inv_o = 1'b0;
        fi_o  = 1'b0;
        case (pol_i)
            POL_SAT_MIN, POL_SAT_ZERO: begin
                inv_o = r_i.nan || oor;
                fi_o  = lost && !oor;
                if (r_i.nan)    res_o = (pol_i == POL_SAT_MIN) ? kind_min(kind_i) : '0;
                else if (over)  res_o = kind_max(kind_i);
                else if (under) res_o = kind_min(kind_i);
                else            res_o = fit_kind(kind_i, signed_v);
            end
            POL_WRAP: begin
                inv_o = r_i.nan || r_i.inf;
                fi_o  = lost;
                if (!(r_i.nan || r_i.inf)) res_o = fit_kind(kind_i, signed_v);
            end
            default: ;
        endcase
        fr_o  = fi_o && r_i.incr;
        ovf_o = r_i.nan || oor || lost;
    end

endmodule

// File: rtl/fp_to_int_cvt.sv
module fp_to_int_cvt
    import f2i_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [DBL_W-1:0] fp_bits,
    input  logic [1:0]       int_kind,
    input  logic [2:0]       conv_mode,
    input  logic [1:0]       rnd_mode,
    input  logic             single_sel,
    input  logic             ov_enable,
    input  logic             inv_trap_en,
    output logic             out_valid,
    output logic [INT_W-1:0] result,
    output logic             wr_en,
    output logic             bad_mode,
    output logic             ov_flag,
    output logic             inv_cvt,
    output logic             snan_flag,
    output logic             fi_flag,
    output logic             fr_flag,
    output logic [3:0]       cr0
);
    unpacked_t        unp;
    rounded_t         rnd;
    logic             snan_w;
    policy_e          pol;
    rnd_e             rm_eff;
    int_kind_e        kind;
    logic [INT_W-1:0] pol_res;
    logic             pol_inv;
    logic             pol_ovf;
    logic             pol_fi;
    logic             pol_fr;
    logic             bad_w;
    logic             trap_w;
    logic             write_w;
    logic [INT_W-1:0] nxt_res;
    logic             nxt_ov;
    logic [3:0]       nxt_cr;

    assign pol    = decode_policy(conv_mode);
    assign rm_eff = conv_mode[0] ? RM_ZERO : rnd_e'(rnd_mode);
    assign kind   = int_kind_e'(int_kind);

    f2i_unpack u_unpack (
        .bits_i   (fp_bits),
        .narrow_i (single_sel),
        .u_o      (unp),
        .snan_o   (snan_w)
    );

    f2i_round u_round (
        .u_i  (unp),
        .rm_i (rm_eff),
        .r_o  (rnd)
    );

    f2i_policy u_policy (
        .r_i    (rnd),
        .kind_i (kind),
        .pol_i  (pol),
        .res_o  (pol_res),
        .inv_o  (pol_inv),
        .ovf_o  (pol_ovf),
        .fi_o   (pol_fi),
        .fr_o   (pol_fr)
    );

    // gating for illegal mode and enabled invalid trap
    always_comb begin
        bad_w   = (pol == POL_BAD);
        trap_w  = !bad_w && inv_trap_en && (pol_inv || snan_w);
        write_w = !bad_w && !trap_w;
        nxt_res = write_w ? pol_res : '0;
        nxt_ov  = write_w && ov_enable && pol_ovf;
        nxt_cr  = '0;
        if (write_w) begin
            nxt_cr[3] = nxt_res[INT_W-1];
            nxt_cr[1] = (nxt_res == '0);
            nxt_cr[2] = !nxt_res[INT_W-1] && (nxt_res != '0);
            nxt_cr[0] = nxt_ov;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            wr_en     <= 1'b0;
            bad_mode  <= 1'b0;
            ov_flag   <= 1'b0;
            inv_cvt   <= 1'b0;
            snan_flag <= 1'b0;
            fi_flag   <= 1'b0;
            fr_flag   <= 1'b0;
            cr0       <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result    <= nxt_res;
                wr_en     <= write_w;
                bad_mode  <= bad_w;
                ov_flag   <= nxt_ov;
                inv_cvt   <= !bad_w && pol_inv;
                snan_flag <= !bad_w && snan_w;
                fi_flag   <= write_w && pol_fi;
                fr_flag   <= write_w && pol_fr;
                cr0       <= nxt_cr;
            end
        end
    end

    p_follow_r13: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);
    p_idle_r13: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid);
    p_bad_nowrite_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid && bad_mode |-> !wr_en && result == '0 && !inv_cvt && cr0 == '0);
    p_trap_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid && !wr_en && !bad_mode |-> !fi_flag && !fr_flag && !ov_flag && result == '0);
    p_cr0_one_r12: assert property (@(posedge clk) disable iff (rst)
        out_valid && wr_en |-> $countones(cr0[3:1]) == 1);
    p_so_mirror_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> cr0[0] == ov_flag);
    p_fr_needs_fi_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid && fr_flag |-> fi_flag);
    p_sext_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid && int_kind == 2'd0 |-> pol_res[INT_W-1:HALF_W] == {HALF_W{pol_res[HALF_W-1]}});

endmodule

// File: tb/fp_to_int_cvt_tb.sv
module fp_to_int_cvt_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] fp_bits = '0;
    logic [1:0]  int_kind = '0;
    logic [2:0]  conv_mode = '0;
    logic [1:0]  rnd_mode = '0;
    logic        single_sel = 1'b0;
    logic        ov_enable = 1'b0;
    logic        inv_trap_en = 1'b0;
    logic        out_valid;
    logic [63:0] result;
    logic        wr_en, bad_mode, ov_flag, inv_cvt, snan_flag, fi_flag, fr_flag;
    logic [3:0]  cr0;

    always #4 clk = ~clk;

    fp_to_int_cvt u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .fp_bits(fp_bits),
        .int_kind(int_kind), .conv_mode(conv_mode), .rnd_mode(rnd_mode),
        .single_sel(single_sel), .ov_enable(ov_enable), .inv_trap_en(inv_trap_en),
        .out_valid(out_valid), .result(result), .wr_en(wr_en), .bad_mode(bad_mode),
        .ov_flag(ov_flag), .inv_cvt(inv_cvt), .snan_flag(snan_flag),
        .fi_flag(fi_flag), .fr_flag(fr_flag), .cr0(cr0)
    );

    int          checks = 0;
    int          failures = 0;
    bit          finished = 1'b0;
    logic [74:0] exp_q[$];
    string       tag_q[$];
    logic [74:0] got;
    logic [74:0] e_v;
    string       t_v;

    // packed view: result, {we,bad,ov,inv,snan,fi,fr}, cr0
    assign got = {result, wr_en, bad_mode, ov_flag, inv_cvt, snan_flag, fi_flag, fr_flag, cr0};

    task automatic note(input bit ok, input string tag, input logic [74:0] act, input logic [74:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // monitor: compare each result against the oldest expectation
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                note(1'b0, "R13 unexpected out_valid", got, '0);
            end else begin
                e_v = exp_q.pop_front();
                t_v = tag_q.pop_front();
                note(got === e_v, t_v, got, e_v);
            end
        end
    end

    task automatic drive(input logic [63:0] fp, input logic [1:0] kind, input logic [2:0] mode,
                         input logic [1:0] rm, input logic sgl, input logic oe, input logic ve,
                         input logic [63:0] e_res, input logic [6:0] e_flags,
                         input logic [3:0] e_cr, input string tag);
        @(negedge clk);
        fp_bits     = fp;
        int_kind    = kind;
        conv_mode   = mode;
        rnd_mode    = rm;
        single_sel  = sgl;
        ov_enable   = oe;
        inv_trap_en = ve;
        in_valid    = 1'b1;
        exp_q.push_back({e_res, e_flags, e_cr});
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        note(out_valid == 1'b0 && result == '0 && wr_en == 1'b0 && cr0 == '0,
             "R13 reset state", got, '0);
        //     operand               kd mode   rm   s  oe ve  result                 we b ov iv sn fi fr  cr0
        drive(64'h4004000000000000, 0, 3'b000, 2'd0, 0, 1, 0, 64'd2,                 7'b1010010, 4'b0101, "R3 2.5 nearest-even");
        drive(64'h400C000000000000, 0, 3'b000, 2'd0, 0, 0, 0, 64'd4,                 7'b1000011, 4'b0100, "R3 3.5 nearest-even up");
        drive(64'h4004000000000000, 0, 3'b001, 2'd0, 0, 0, 0, 64'd2,                 7'b1000010, 4'b0100, "R3 mode bit0 truncate");
        drive(64'hC004000000000000, 0, 3'b000, 2'd2, 0, 0, 0, 64'hFFFFFFFFFFFFFFFE,  7'b1000010, 4'b1000, "R3 -2.5 toward +inf");
        drive(64'hC004000000000000, 0, 3'b000, 2'd3, 0, 0, 0, 64'hFFFFFFFFFFFFFFFD,  7'b1000011, 4'b1000, "R3 -2.5 toward -inf");
        drive(64'h3FF8000000000000, 0, 3'b000, 2'd1, 0, 0, 0, 64'd1,                 7'b1000010, 4'b0100, "R3 1.5 toward zero");
        drive(64'h3FF8000000000000, 0, 3'b001, 2'd2, 0, 0, 0, 64'd1,                 7'b1000010, 4'b0100, "R3 truncate overrides ceil");
        drive(64'hBFF0000000000000, 1, 3'b010, 2'd0, 0, 1, 0, 64'd0,                 7'b1011000, 4'b0011, "R4 -1 to u32 saturates");
        drive(64'h41F0000000500000, 1, 3'b000, 2'd0, 0, 0, 0, 64'h00000000FFFFFFFF,  7'b1001000, 4'b0100, "R4 2^32+5 u32 max");
        drive(64'h4450000000000000, 2, 3'b010, 2'd0, 0, 1, 0, 64'h7FFFFFFFFFFFFFFF,  7'b1011000, 4'b0101, "R4 2^70 s64 max");
        drive(64'hFFF0000000000000, 0, 3'b000, 2'd0, 0, 0, 0, 64'hFFFFFFFF80000000,  7'b1001000, 4'b1000, "R4 -inf s32 min");
        drive(64'hC3E0000000000000, 2, 3'b000, 2'd0, 0, 1, 0, 64'h8000000000000000,  7'b1000000, 4'b1000, "R4 -2^63 exact s64");
        drive(64'h43E0000000000000, 2, 3'b000, 2'd0, 0, 0, 0, 64'h7FFFFFFFFFFFFFFF,  7'b1001000, 4'b0100, "R4 2^63 s64 saturates");
        drive(64'h7FF8000000000000, 0, 3'b000, 2'd0, 0, 1, 0, 64'hFFFFFFFF80000000,  7'b1011000, 4'b1001, "R5 qNaN policy min");
        drive(64'h7FF8000000000000, 2, 3'b010, 2'd0, 0, 0, 0, 64'd0,                 7'b1001000, 4'b0010, "R5 qNaN policy zero");
        drive(64'h7FF0000000000000, 0, 3'b100, 2'd0, 0, 0, 0, 64'd0,                 7'b1001000, 4'b0010, "R5 +inf wrap zero");
        drive(64'h7FF8000000000000, 3, 3'b101, 2'd0, 0, 0, 0, 64'd0,                 7'b1001000, 4'b0010, "R5 qNaN wrap zero");
        drive(64'h7FF0000000000001, 3, 3'b000, 2'd0, 0, 0, 0, 64'd0,                 7'b1001100, 4'b0010, "R8 sNaN flagged");
        drive(64'h41F0000000500000, 0, 3'b100, 2'd0, 0, 1, 0, 64'd5,                 7'b1010000, 4'b0101, "R6 2^32+5 wraps to 5");
        drive(64'h41E0000000000000, 0, 3'b101, 2'd0, 0, 1, 0, 64'hFFFFFFFF80000000,  7'b1010000, 4'b1001, "R6 2^31 wraps negative");
        drive(64'hBFF0000000000000, 1, 3'b100, 2'd0, 0, 0, 0, 64'h00000000FFFFFFFF,  7'b1000000, 4'b0100, "R6 -1 wraps u32 zext");
        drive(64'h4450000000000000, 2, 3'b100, 2'd0, 0, 1, 0, 64'd0,                 7'b1010000, 4'b0011, "R6 2^70 wraps to 0");
        drive(64'h43E0000000000000, 3, 3'b000, 2'd0, 0, 1, 0, 64'h8000000000000000,  7'b1000000, 4'b1000, "R1 2^63 fits u64");
        drive(64'hC008000000000000, 2, 3'b000, 2'd0, 0, 0, 0, 64'hFFFFFFFFFFFFFFFD,  7'b1000000, 4'b1000, "R1 -3 s64");
        drive(64'hC008000000000000, 0, 3'b000, 2'd0, 0, 0, 0, 64'hFFFFFFFFFFFFFFFD,  7'b1000000, 4'b1000, "R1 -3 s32 sext");
        drive(64'h7FF8000000000000, 0, 3'b000, 2'd0, 0, 1, 1, 64'd0,                 7'b0001000, 4'b0000, "R9 NaN trapped");
        drive(64'h4450000000000000, 0, 3'b000, 2'd0, 0, 1, 1, 64'd0,                 7'b0001000, 4'b0000, "R9 range trapped");
        drive(64'h4004000000000000, 0, 3'b000, 2'd0, 0, 0, 1, 64'd2,                 7'b1000010, 4'b0100, "R9 valid not trapped");
        drive(64'h4004000000000000, 0, 3'b110, 2'd0, 0, 1, 0, 64'd0,                 7'b0100000, 4'b0000, "R2 mode 110 illegal");
        drive(64'h7FF8000000000000, 0, 3'b111, 2'd0, 0, 1, 1, 64'd0,                 7'b0100000, 4'b0000, "R2 mode 111 illegal");
        drive(64'h41D0000000200000, 0, 3'b000, 2'd2, 0, 0, 0, 64'h0000000040000001,  7'b1000011, 4'b0100, "R11 double keeps low fraction");
        drive(64'h41D0000000200000, 0, 3'b000, 2'd2, 1, 1, 0, 64'h0000000040000000,  7'b1000000, 4'b0100, "R11 single drops low fraction");
        drive(64'h8000000000000000, 0, 3'b000, 2'd0, 0, 1, 0, 64'd0,                 7'b1000000, 4'b0010, "R10 negative zero exact");
        drive(64'h3FE0000000000000, 1, 3'b000, 2'd2, 0, 1, 0, 64'd1,                 7'b1010011, 4'b0101, "R7 0.5 ceil overflow");
        drive(64'h3FE0000000000000, 1, 3'b000, 2'd0, 0, 1, 0, 64'd0,                 7'b1010010, 4'b0011, "R12 0.5 even to zero");
        idle();
        repeat (4) idle();
        note(exp_q.size() == 0, "R13 results outstanding", 75'(exp_q.size()), '0);
        report();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL R13 watchdog expired actual=hung expected=done");
            report();
        end
    end

endmodule